// File: doc/BRIEF.md
# Paged Effective Address Unit

This block produces the operand effective address for a 12-bit single-address processor. The processor's memory is split into fixed pages of 128 words. A start pulse presents the instruction word, the address of that instruction, and two 3-bit bank selectors: one for instruction space and one for operand space. A 7-bit offset in the instruction picks a word. That word sits either in page zero or in the page that holds the instruction.

A direct reference finishes at once. An indirect reference reads the addressed word over a single-port memory handshake and uses that word as the operand address. Eight fixed locations act as self-incrementing pointers. When one of them is used indirectly, the block reads it, adds one, writes the new value back, and then uses the new value. Addresses leave the block 15 bits wide, with a bank selector in the upper three bits.

It sits between instruction decode and the operand access stage. A done pulse hands the finished address to the next stage.

Top module: `paged_ea_unit`

## Requirements
- R1: After reset, done_o and mem_req_o are low.
- R2: When instruction bit 8 (indirect flag, LSB = bit 0) is 0 and bit 7 (page select) is 0, ea_o = {ifield, 5'b0, instr[6:0]}. done_o rises one cycle after the start cycle, and no memory request is made.
- R3: When bit 8 is 0 and bit 7 is 1, ea_o = {ifield, pc[11:7], instr[6:0]}, where pc is the address of the instruction itself.
- R4: When bit 8 is 1, exactly one read is made at {ifield, direct address}, and ea_o = {dfield, word read}.
- R5: A memory request holds its address, direction and data until mem_ack_i is high on a clock edge. The acknowledge may come in the first request cycle, and each waiting cycle adds one cycle of latency.
- R6: An indirect reference whose 12-bit direct address is in octal 0010..0017 reads the word, writes word+1 to the same address, and yields ea_o = {dfield, word+1}.
- R7: The pointer increment wraps modulo 4096 (7777 octal becomes 0000).
- R8: Indirect references through octal 0007 and 0020 make no write.
- R9: The self-increment range applies to the computed address, so a current-page reference hits it only while the instruction lies in page zero.
- R10: done_o is a one-cycle pulse. A start in the done cycle is accepted. A start while a memory access is in progress is ignored.
- R11: The bank selectors and the instruction are captured at start. Later changes to them do not affect the running reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an address computation |
| instr_i | input | 12 | Instruction word |
| pc_i | input | 12 | Address of the instruction |
| ifield_i | input | 3 | Instruction-space bank |
| dfield_i | input | 3 | Operand-space bank |
| done_o | output | 1 | Effective address ready (one cycle) |
| ea_o | output | 15 | Effective address, bank in top 3 bits |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 15 | Request address |
| mem_wdata_o | output | 12 | Write data |
| mem_rdata_i | input | 12 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Request accepted this cycle |

## Verification
Two things can fall in the same cycle: one reference finishing, with done_o high, and the next reference being accepted. The bench issues each new start in the very cycle it sees done_o. It mixes direct, indirect and self-incrementing references so that the overlap happens after each kind. A scoreboard then checks each address and the memory traffic of both the finishing and the following reference. A second pairing, a start that arrives while a read is still waiting, is provoked with a slow memory and changed bank inputs. It is judged by the absence of any extra done pulse and by the unchanged result.

// File: rtl/pea_pkg.sv
package pea_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_FIN   = 2'd3
   } pea_state_t;
endpackage

// File: rtl/pea_addr_form.sv
module pea_addr_form #(
   parameter int WORD_W    = 12,
   parameter int OFFS_W    = 7,
   parameter int AUTO_BASE = 8,
   parameter int AUTO_CNT  = 8,
   parameter bit AUTO_EN   = 1'b1
) (
   input  logic [WORD_W-1:0] instr_i,
   input  logic [WORD_W-1:0] pc_i,
   output logic [WORD_W-1:0] dir_o,
   output logic              ind_o,
   output logic              auto_o
);
   localparam int PAGE_W  = WORD_W - OFFS_W;
   localparam int AUTO_TOP = AUTO_BASE + AUTO_CNT;

   if (OFFS_W + 2 > WORD_W) begin : g_chk_fmt
      $error("instruction too narrow for offset, page and indirect bits");
   end
   if (AUTO_TOP > (1 << OFFS_W)) begin : g_chk_auto
      $error("self-increment range must lie inside page zero");
   end

   logic [OFFS_W-1:0] offs;
   logic              cur_page;
   logic [PAGE_W-1:0] page;

   assign offs     = instr_i[OFFS_W-1:0];
   assign cur_page = instr_i[OFFS_W];
   assign ind_o    = instr_i[OFFS_W+1];
   assign page     = cur_page ? pc_i[WORD_W-1:OFFS_W] : '0;
   assign dir_o    = {page, offs};

   logic unused_bits;
   assign unused_bits = ^{instr_i[WORD_W-1:OFFS_W+1], pc_i[OFFS_W-1:0]};

   if (AUTO_EN) begin : g_auto
      assign auto_o = ({1'b0, dir_o} >= (WORD_W+1)'(AUTO_BASE)) &&
                      ({1'b0, dir_o} <  (WORD_W+1)'(AUTO_TOP));
   end else begin : g_no_auto
      assign auto_o = 1'b0;
   end
endmodule

// File: rtl/pea_field_join.sv
module pea_field_join #(
   parameter int FIELD_W = 3,
   parameter int WORD_W  = 12,
   parameter bit EXT_EN  = 1'b1
) (
   input  logic [FIELD_W-1:0]        field_i,
   input  logic [WORD_W-1:0]         word_i,
   output logic [FIELD_W+WORD_W-1:0] phys_o
);
   if (FIELD_W < 1) begin : g_chk_fw
      $error("bank selector must be at least one bit");
   end

   if (EXT_EN) begin : g_ext
      assign phys_o = {field_i, word_i};
   end else begin : g_flat
      logic unused_field;
      assign unused_field = ^field_i;
      assign phys_o = {{FIELD_W{1'b0}}, word_i};
   end
endmodule

// File: rtl/pea_seq.sv
module pea_seq
   import pea_pkg::*;
#(
   parameter int FIELD_W = 3,
   parameter int WORD_W  = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic                      ind_i,
   input  logic                      auto_i,
   input  logic [FIELD_W+WORD_W-1:0] ptr_phys_i,
   input  logic [FIELD_W-1:0]        df_i,
   input  logic [WORD_W-1:0]         mem_rdata_i,
   input  logic                      mem_ack_i,
   output logic                      done_o,
   output logic                      mem_req_o,
   output logic                      mem_we_o,
   output logic [FIELD_W+WORD_W-1:0] mem_addr_o,
   output logic [WORD_W-1:0]         mem_wdata_o,
   output logic [FIELD_W-1:0]        res_field_o,
   output logic [WORD_W-1:0]         res_word_o
);
   localparam int PA_W = FIELD_W + WORD_W;

   pea_state_t        state_q;
   logic [PA_W-1:0]   ptr_q;
   logic              auto_q;
   logic [FIELD_W-1:0] df_q;
   logic [FIELD_W-1:0] field_q;
   logic [WORD_W-1:0]  word_q;
   logic              accept;

   assign accept = start_i && ((state_q == ST_IDLE) || (state_q == ST_FIN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ptr_q   <= '0;
         auto_q  <= 1'b0;
         df_q    <= '0;
         field_q <= '0;
         word_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE, ST_FIN: begin
               if (accept) begin
                  ptr_q  <= ptr_phys_i;
                  auto_q <= auto_i;
                  df_q   <= df_i;
                  if (ind_i) begin
                     state_q <= ST_READ;
                  end else begin
                     field_q <= ptr_phys_i[PA_W-1:WORD_W];
                     word_q  <= ptr_phys_i[WORD_W-1:0];
                     state_q <= ST_FIN;
                  end
               end else begin
                  state_q <= ST_IDLE;
               end
            end
            ST_READ: begin
               if (mem_ack_i) begin
                  field_q <= df_q;
                  if (auto_q) begin
                     word_q  <= mem_rdata_i + 1'b1;
                     state_q <= ST_WRITE;
                  end else begin
                     word_q  <= mem_rdata_i;
                     state_q <= ST_FIN;
                  end
               end
            end
            ST_WRITE: begin
               if (mem_ack_i) begin
                  state_q <= ST_FIN;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done_o      = (state_q == ST_FIN);
   assign mem_req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
   assign mem_we_o    = (state_q == ST_WRITE);
   assign mem_addr_o  = ptr_q;
   assign mem_wdata_o = word_q;
   assign res_field_o = field_q;
   assign res_word_o  = word_q;

   // R10: done lasts one cycle unless a new direct reference is taken
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start_i |=> !done_o);

   // R5: a waiting request keeps address and direction
   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

   // R4: the first request goes to the pointer address seen at start
   a_r4_ptr_addr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_o) |-> mem_addr_o == $past(ptr_phys_i) && !mem_we_o);

   // R6: a write only follows an acknowledged read
   a_r6_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_o) |-> $past(mem_req_o && !mem_we_o && mem_ack_i));

   // R7: written word is the read word plus one, modulo the word size
   a_r7_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_o) |-> mem_wdata_o == WORD_W'($past(mem_rdata_i) + 1'b1));
endmodule

// File: rtl/paged_ea_unit.sv
module paged_ea_unit #(
   parameter int WORD_W    = 12,
   parameter int OFFS_W    = 7,
   parameter int FIELD_W   = 3,
   parameter int AUTO_BASE = 8,
   parameter int AUTO_CNT  = 8,
   parameter bit AUTO_EN   = 1'b1,
   parameter bit EXT_EN    = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [WORD_W-1:0]         instr_i,
   input  logic [WORD_W-1:0]         pc_i,
   input  logic [FIELD_W-1:0]        ifield_i,
   input  logic [FIELD_W-1:0]        dfield_i,
   output logic                      done_o,
   output logic [FIELD_W+WORD_W-1:0] ea_o,
   output logic                      mem_req_o,
   output logic                      mem_we_o,
   output logic [FIELD_W+WORD_W-1:0] mem_addr_o,
   output logic [WORD_W-1:0]         mem_wdata_o,
   input  logic [WORD_W-1:0]         mem_rdata_i,
   input  logic                      mem_ack_i
);
   localparam int PA_W = FIELD_W + WORD_W;

   logic [WORD_W-1:0]  dir_addr;
   logic               ind;
   logic               auto_hit;
   logic [PA_W-1:0]    ptr_phys;
   logic [FIELD_W-1:0] res_field;
   logic [WORD_W-1:0]  res_word;

   pea_addr_form #(
      .WORD_W(WORD_W), .OFFS_W(OFFS_W),
      .AUTO_BASE(AUTO_BASE), .AUTO_CNT(AUTO_CNT), .AUTO_EN(AUTO_EN)
   ) form_i (
      .instr_i(instr_i), .pc_i(pc_i),
      .dir_o(dir_addr), .ind_o(ind), .auto_o(auto_hit)
   );

   pea_field_join #(.FIELD_W(FIELD_W), .WORD_W(WORD_W), .EXT_EN(EXT_EN)) ptr_join_i (
      .field_i(ifield_i), .word_i(dir_addr), .phys_o(ptr_phys)
   );

   pea_seq #(.FIELD_W(FIELD_W), .WORD_W(WORD_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .ind_i(ind), .auto_i(auto_hit), .ptr_phys_i(ptr_phys), .df_i(dfield_i),
      .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
      .done_o(done_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
      .res_field_o(res_field), .res_word_o(res_word)
   );

   pea_field_join #(.FIELD_W(FIELD_W), .WORD_W(WORD_W), .EXT_EN(EXT_EN)) ea_join_i (
      .field_i(res_field), .word_i(res_word), .phys_o(ea_o)
   );

   // R1: nothing is requested or reported right after reset
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> !done_o && !mem_req_o);

   // R2: a direct reference that starts from idle ends with no memory traffic
   a_r2_direct_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !ind && !done_o && !mem_req_o |=> done_o && !mem_req_o);
endmodule

// File: tb/paged_ea_unit_tb_top.sv
`timescale 1ns/1ps
module paged_ea_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [11:0] instr_i = '0;
   logic [11:0] pc_i = '0;
   logic [2:0]  ifield_i = '0;
   logic [2:0]  dfield_i = '0;
   logic        done_o;
   logic [14:0] ea_o;
   logic        mem_req_o;
   logic        mem_we_o;
   logic [14:0] mem_addr_o;
   logic [11:0] mem_wdata_o;
   logic [11:0] mem_rdata_i = '0;
   logic        mem_ack_i = 1'b0;

   always #4 clk = ~clk;

   paged_ea_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i), .pc_i(pc_i),
      .ifield_i(ifield_i), .dfield_i(dfield_i), .done_o(done_o), .ea_o(ea_o),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i)
   );

   typedef struct {
      logic [14:0] ea;
      int          nrd;
      int          nwr;
      logic [14:0] rd_addr;
      logic [11:0] wr_data;
      string       req;
   } exp_t;

   exp_t        sb_q[$];
   logic [11:0] mem[int];
   int          tests = 0;
   int          fails = 0;
   int          lat = 0;
   int          wcnt = 0;
   int          seen_rd = 0;
   int          seen_wr = 0;
   logic [14:0] seen_rd_addr = '0;
   logic [11:0] seen_wr_data = '0;
   bit          finished = 1'b0;

   function automatic logic [11:0] peek(logic [14:0] a);
      if (mem.exists(int'(a))) return mem[int'(a)];
      return 12'((int'(a) * 7 + 5) & 12'hfff);
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   // memory model and scoreboard monitor, both at the falling edge
   always @(negedge clk) begin
      if (done_o) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R10", "unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(ea_o == e.ea, e.req, "ea", int'(ea_o), int'(e.ea));
            check(seen_rd == e.nrd, e.req, "read count", seen_rd, e.nrd);
            check(seen_wr == e.nwr, e.req, "write count", seen_wr, e.nwr);
            if (e.nrd > 0)
               check(seen_rd_addr == e.rd_addr, e.req, "read addr",
                     int'(seen_rd_addr), int'(e.rd_addr));
            if (e.nwr > 0)
               check(seen_wr_data == e.wr_data, e.req, "write data",
                     int'(seen_wr_data), int'(e.wr_data));
         end
         seen_rd = 0;
         seen_wr = 0;
      end
      if (mem_req_o) begin
         if (wcnt >= lat) begin
            mem_ack_i = 1'b1;
            wcnt = 0;
            if (mem_we_o) begin
               mem[int'(mem_addr_o)] = mem_wdata_o;
               seen_wr++;
               seen_wr_data = mem_wdata_o;
            end else begin
               mem_rdata_i = peek(mem_addr_o);
               seen_rd++;
               seen_rd_addr = mem_addr_o;
            end
         end else begin
            mem_ack_i = 1'b0;
            wcnt++;
         end
      end else begin
         mem_ack_i = 1'b0;
         wcnt = 0;
      end
   end

   function automatic logic [11:0] mk(bit ind, bit cur, logic [6:0] offs);
      return {3'b101, ind, cur, offs};
   endfunction

   // driver: computes expectation, pushes it, then runs one reference
   task automatic run_op(logic [11:0] ins, logic [11:0] pc, logic [2:0] fi, logic [2:0] fd,
                         int l, bit spur, string req);
      exp_t        e;
      logic [11:0] dir;
      logic [11:0] w;
      int          cyc;
      int          exp_cyc;
      dir = ins[7] ? {pc[11:7], ins[6:0]} : {5'b0, ins[6:0]};
      e.req = req; e.nrd = 0; e.nwr = 0; e.rd_addr = {fi, dir}; e.wr_data = '0;
      if (!ins[8]) begin
         e.ea = {fi, dir};
         exp_cyc = 1;
      end else begin
         w = peek({fi, dir});
         e.nrd = 1;
         if (dir >= 12'o0010 && dir <= 12'o0017) begin
            w = w + 12'd1;
            e.nwr = 1;
            e.wr_data = w;
            exp_cyc = 3 + 2 * l;
         end else begin
            exp_cyc = 2 + l;
         end
         e.ea = {fd, w};
      end
      sb_q.push_back(e);
      lat = l;
      instr_i = ins; pc_i = pc; ifield_i = fi; dfield_i = fd; start_i = 1'b1;
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
         if (cyc == 1) begin
            start_i = spur;
            if (spur) begin
               instr_i = mk(1'b0, 1'b1, 7'h55); pc_i = 12'hfff;
               ifield_i = ~fi; dfield_i = ~fd;
            end
         end else if (cyc == 2) begin
            start_i = 1'b0;
         end
      end while (!done_o && cyc < 500);
      check(cyc == exp_cyc, req, "latency", cyc, exp_cyc);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "WDOG", "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(done_o == 1'b0, "R1", "done after reset", int'(done_o), 0);
      check(mem_req_o == 1'b0, "R1", "req after reset", int'(mem_req_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done_o == 1'b0 && mem_req_o == 1'b0, "R1", "idle after release",
            int'({done_o, mem_req_o}), 0);

      // R2 / R3 direct references
      run_op(mk(0, 0, 7'o123), 12'o3456, 3'd2, 3'd5, 0, 0, "R2");
      @(negedge clk);
      run_op(mk(0, 1, 7'o025), 12'o3456, 3'd6, 3'd1, 0, 0, "R3");
      @(negedge clk);

      // R4 / R5 indirect with varying acknowledge delay
      run_op(mk(1, 0, 7'o040), 12'o1200, 3'd1, 3'd4, 1, 0, "R4");
      run_op(mk(1, 1, 7'o101), 12'o2345, 3'd3, 3'd7, 0, 0, "R5");
      run_op(mk(1, 1, 7'o002), 12'o6600, 3'd0, 3'd2, 3, 0, "R5");

      // R6 / R7 self-incrementing pointers
      mem[int'({3'd4, 12'o0012})] = 12'o0477;
      run_op(mk(1, 0, 7'o012), 12'o5000, 3'd4, 3'd6, 2, 0, "R6");
      run_op(mk(1, 0, 7'o012), 12'o5000, 3'd4, 3'd6, 0, 0, "R6");
      check(mem[int'({3'd4, 12'o0012})] == 12'o0501, "R6", "pointer after two uses",
            int'(mem[int'({3'd4, 12'o0012})]), int'(12'o0501));
      mem[int'({3'd1, 12'o0017})] = 12'o7777;
      run_op(mk(1, 0, 7'o017), 12'o0000, 3'd1, 3'd3, 1, 0, "R7");
      check(mem[int'({3'd1, 12'o0017})] == 12'o0000, "R7", "wrapped pointer",
            int'(mem[int'({3'd1, 12'o0017})]), 0);

      // R8 range edges
      run_op(mk(1, 0, 7'o007), 12'o4000, 3'd2, 3'd2, 0, 0, "R8");
      run_op(mk(1, 0, 7'o020), 12'o4000, 3'd2, 3'd2, 1, 0, "R8");

      // R9 current-page reference into the range
      run_op(mk(1, 1, 7'o015), 12'o0044, 3'd5, 3'd0, 0, 0, "R9");
      run_op(mk(1, 1, 7'o015), 12'o0244, 3'd5, 3'd0, 0, 0, "R9");

      // R10 back-to-back starts taken in the done cycle, after each kind
      run_op(mk(0, 0, 7'o001), 12'o0100, 3'd7, 3'd7, 0, 0, "R10");
      run_op(mk(1, 0, 7'o011), 12'o0100, 3'd7, 3'd1, 0, 0, "R10");
      run_op(mk(0, 1, 7'o177), 12'o7777, 3'd3, 3'd3, 0, 0, "R10");
      run_op(mk(1, 0, 7'o050), 12'o0100, 3'd6, 3'd2, 2, 0, "R10");
      run_op(mk(1, 0, 7'o013), 12'o0100, 3'd0, 3'd5, 1, 0, "R10");
      @(negedge clk);

      // R10 / R11 start during a pending read, with changed banks
      run_op(mk(1, 0, 7'o060), 12'o3000, 3'd2, 3'd6, 3, 1, "R11");
      @(negedge clk);
      run_op(mk(1, 0, 7'o014), 12'o3000, 3'd5, 3'd1, 2, 1, "R11");
      repeat (3) @(negedge clk);
      check(sb_q.size() == 0, "R10", "missing done pulses", sb_q.size(), 0);
      check(done_o == 1'b0, "R10", "done idle at end", int'(done_o), 0);
      summary();
   end
endmodule